// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of an SDRAM device from reset until the device can accept normal traffic. Once reset is released it keeps clock enable and every data mask high and drives only no-operation commands for a settle period, counted in clock cycles from the clock frequency and the required settle time. It then precharges all banks, runs a set of auto-refresh commands, and loads the mode register. Each command is followed by a programmable run of no-operation cycles before the next step.

The mode register word is assembled from four configuration inputs: burst length, burst type, CAS latency and write burst mode. The word is checked at the moment it would be sent. A reserved or contradictory setting stops the sequence: no mode load is sent, an error flag rises, and the pins stay at no-operation. A parameter moves the mode load ahead of the refresh phase. When the last gap has elapsed a ready flag rises and stays high until the next reset.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low and at all times after it, clock enable is 1, every data mask bit is 1, the bank address is 0, and any no-operation cycle shows {cs_n,ras_n,cas_n,we_n}=0111 with the address bus at 0.
- R2: The first command other than no-operation is a precharge-all ({cs_n,ras_n,cas_n,we_n}=0010, address bit 10 high, all other address bits 0). It appears exactly CLK_FREQ_MHZ*SETTLE_US cycles after reset is released.
- R3: Exactly max(NUM_REF,2) auto-refresh commands (0001, address 0) are sent, so a NUM_REF of 1 still yields two.
- R4: The mode load command is 0000. Its address carries burst length in bits 2:0, burst type in bit 3 (0 sequential, 1 interleave), CAS latency in bits 6:4, 00 in bits 8:7, the write mode in bit 9 (0 burst write, 1 single-location write), and 0 in every higher bit.
- R5: With MRS_FIRST=0 the order is precharge, refreshes, mode load. With MRS_FIRST=1 it is precharge, mode load, refreshes.
- R6: Exactly TRP_CYC no-operation cycles follow the precharge, TRC_CYC follow each refresh, and TMRD_CYC follow the mode load, before the next command or before ready.
- R7: Burst length codes 000, 001, 010, 011 and 111 are accepted; 100, 101 and 110 are rejected.
- R8: Burst length 111 (full page) combined with burst type 1 is rejected.
- R9: Only CAS latency codes 010 and 011 are accepted; all others are rejected.
- R10: On a rejected setting, no mode load is sent. The error output rises in the cycle the mode load would have appeared, and no further command is sent until reset. Ready stays low.
- R11: Ready rises in the first cycle after the final gap and stays high until reset. Configuration changes after that send no command.
- R12: Asserting reset in the middle of a sequence returns the pins to no-operation and restarts the full sequence, including the settle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_burst_type | input | 1 | 0 sequential, 1 interleave |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_wr_single | input | 1 | 1 selects single-location writes |
| sdram_cke | output | 1 | Clock enable |
| sdram_cs_n | output | 1 | Chip select, active low |
| sdram_ras_n | output | 1 | Row strobe, active low |
| sdram_cas_n | output | 1 | Column strobe, active low |
| sdram_we_n | output | 1 | Write enable, active low |
| sdram_dqm | output | DQM_W | Data masks, held high |
| sdram_ba | output | BA_W | Bank address, held 0 |
| sdram_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Sequence finished |
| init_err | output | 1 | Configuration rejected |

## Verification
The full sequence runs once for each of nine configurations. Five are legal and cover every accepted burst length with both burst types, both CAS latencies and both write modes, which exposes bit-placement errors in the mode word. The other four are each rejected for a different reason: a reserved burst length, full page with interleave, and a CAS code below and above the legal pair. This separates the three rejection rules. Two instances run side by side, one per ordering, and the swapped one is given a refresh count of one so the minimum of two is visible. A directed mid-sequence reset and a configuration change after ready cover restart and the inert ready state.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001,
        CMD_MRS = 4'b0000
    } cmd_e;

    typedef enum logic [2:0] {
        ST_SETTLE = 3'd0,
        ST_TRP    = 3'd1,
        ST_TRC    = 3'd2,
        ST_TMRD   = 3'd3,
        ST_READY  = 3'd4,
        ST_ERR    = 3'd5
    } init_state_e;

    localparam logic [2:0] BL_FULL_PAGE = 3'b111;

    function automatic logic burst_len_ok(input logic [2:0] code);
        return (code <= 3'b011) || (code == BL_FULL_PAGE);
    endfunction

    function automatic logic cas_lat_ok(input logic [2:0] code);
        return (code == 3'b010) || (code == 3'b011);
    endfunction

endpackage

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
    parameter int ADDR_W = 13
) (
    input  logic [2:0]        burst_len,
    input  logic              burst_type,
    input  logic [2:0]        cas_lat,
    input  logic              wr_single,
    output logic [ADDR_W-1:0] word,
    output logic              legal
);
    import sdram_init_pkg::*;

    logic full_page_conflict;

    always_comb begin
        word      = '0;
        word[2:0] = burst_len;
        word[3]   = burst_type;
        word[6:4] = cas_lat;
        word[8:7] = 2'b00;
        word[9]   = wr_single;
    end

    assign full_page_conflict = (burst_len == BL_FULL_PAGE) && burst_type;
    assign legal = burst_len_ok(burst_len) && cas_lat_ok(cas_lat) && !full_page_conflict;

endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl #(
    parameter int ADDR_W     = 13,
    parameter int SETTLE_CYC = 20000,
    parameter int TRP_CYC    = 3,
    parameter int TRC_CYC    = 7,
    parameter int TMRD_CYC   = 2,
    parameter int NUM_REF    = 8,
    parameter bit MRS_FIRST  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mode_word,
    input  logic              mode_ok,
    output logic [3:0]        cmd,
    output logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic              err
);
    import sdram_init_pkg::*;

    localparam int NREF_EFF  = (NUM_REF < 2) ? 2 : NUM_REF;
    localparam int REF_W     = $clog2(NREF_EFF + 1);
    localparam int GAP_MAX01 = (TRP_CYC > TRC_CYC) ? TRP_CYC : TRC_CYC;
    localparam int GAP_MAX   = (GAP_MAX01 > TMRD_CYC) ? GAP_MAX01 : TMRD_CYC;
    localparam int CNT_MAX   = (SETTLE_CYC > GAP_MAX) ? SETTLE_CYC : GAP_MAX;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);
    localparam int AP_BIT    = 10;

    typedef struct packed {
        init_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic [REF_W-1:0]  refs;
        cmd_e              cmd;
        logic [ADDR_W-1:0] addr;
        logic              ready;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;
    logic  go_ref, go_mrs, go_done;

    always_comb begin
        r_d      = r_q;
        r_d.cmd  = CMD_NOP;
        r_d.addr = '0;
        go_ref   = 1'b0;
        go_mrs   = 1'b0;
        go_done  = 1'b0;

        case (r_q.st)
            ST_SETTLE: begin
                if (r_q.cnt == CNT_W'(SETTLE_CYC - 1)) begin
                    r_d.cmd          = CMD_PRE;
                    r_d.addr[AP_BIT] = 1'b1;
                    r_d.st           = ST_TRP;
                    r_d.cnt          = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_TRP: begin
                if (r_q.cnt == CNT_W'(TRP_CYC)) begin
                    if (MRS_FIRST) go_mrs = 1'b1;
                    else           go_ref = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_TRC: begin
                if (r_q.cnt == CNT_W'(TRC_CYC)) begin
                    if (r_q.refs != REF_W'(NREF_EFF)) go_ref  = 1'b1;
                    else if (MRS_FIRST)               go_done = 1'b1;
                    else                              go_mrs  = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_TMRD: begin
                if (r_q.cnt == CNT_W'(TMRD_CYC)) begin
                    if (MRS_FIRST) go_ref  = 1'b1;
                    else           go_done = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: ;
        endcase

        if (go_ref) begin
            r_d.cmd  = CMD_REF;
            r_d.refs = r_q.refs + 1'b1;
            r_d.st   = ST_TRC;
            r_d.cnt  = '0;
        end
        if (go_mrs) begin
            if (mode_ok) begin
                r_d.cmd  = CMD_MRS;
                r_d.addr = mode_word;
                r_d.st   = ST_TMRD;
                r_d.cnt  = '0;
            end else begin
                r_d.st  = ST_ERR;
                r_d.err = 1'b1;
            end
        end
        if (go_done) begin
            r_d.st    = ST_READY;
            r_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_SETTLE;
            r_q.cmd   <= CMD_NOP;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd   = r_q.cmd;
    assign addr  = r_q.addr;
    assign ready = r_q.ready;
    assign err   = r_q.err;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
    parameter int ADDR_W       = 13,
    parameter int BA_W         = 2,
    parameter int DQM_W        = 2,
    parameter int CLK_FREQ_MHZ = 100,
    parameter int SETTLE_US    = 200,
    parameter int TRP_CYC      = 3,
    parameter int TRC_CYC      = 7,
    parameter int TMRD_CYC     = 2,
    parameter int NUM_REF      = 8,
    parameter bit MRS_FIRST    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_type,
    input  logic [2:0]        cfg_cas_lat,
    input  logic              cfg_wr_single,
    output logic              sdram_cke,
    output logic              sdram_cs_n,
    output logic              sdram_ras_n,
    output logic              sdram_cas_n,
    output logic              sdram_we_n,
    output logic [DQM_W-1:0]  sdram_dqm,
    output logic [BA_W-1:0]   sdram_ba,
    output logic [ADDR_W-1:0] sdram_addr,
    output logic              init_done,
    output logic              init_err
);
    localparam int SETTLE_CYC = CLK_FREQ_MHZ * SETTLE_US;

    logic [ADDR_W-1:0] mode_word;
    logic              mode_ok;
    logic [3:0]        cmd_bits;

    sdram_mode_word #(.ADDR_W(ADDR_W)) u_word (
        .burst_len (cfg_burst_len),
        .burst_type(cfg_burst_type),
        .cas_lat   (cfg_cas_lat),
        .wr_single (cfg_wr_single),
        .word      (mode_word),
        .legal     (mode_ok)
    );

    sdram_init_ctrl #(
        .ADDR_W    (ADDR_W),
        .SETTLE_CYC(SETTLE_CYC),
        .TRP_CYC   (TRP_CYC),
        .TRC_CYC   (TRC_CYC),
        .TMRD_CYC  (TMRD_CYC),
        .NUM_REF   (NUM_REF),
        .MRS_FIRST (MRS_FIRST)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_word(mode_word),
        .mode_ok  (mode_ok),
        .cmd      (cmd_bits),
        .addr     (sdram_addr),
        .ready    (init_done),
        .err      (init_err)
    );

    assign {sdram_cs_n, sdram_ras_n, sdram_cas_n, sdram_we_n} = cmd_bits;
    assign sdram_cke = 1'b1;
    assign sdram_dqm = '1;
    assign sdram_ba  = '0;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
    parameter int ADDR_W     = 13,
    parameter int BA_W       = 2,
    parameter int DQM_W      = 2,
    parameter int SETTLE_CYC = 20000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sdram_cke,
    input logic              sdram_cs_n,
    input logic              sdram_ras_n,
    input logic              sdram_cas_n,
    input logic              sdram_we_n,
    input logic [DQM_W-1:0]  sdram_dqm,
    input logic [BA_W-1:0]   sdram_ba,
    input logic [ADDR_W-1:0] sdram_addr,
    input logic              init_done,
    input logic              init_err
);
    localparam int AGE_W = $clog2(SETTLE_CYC + 2);

    logic [3:0]       cmd;
    logic [AGE_W-1:0] age_q;

    assign cmd = {sdram_cs_n, sdram_ras_n, sdram_cas_n, sdram_we_n};

    always_ff @(posedge clk) begin
        if (!rst_n)                            age_q <= '0;
        else if (age_q != AGE_W'(SETTLE_CYC)) age_q <= age_q + 1'b1;
    end

    assert_pins_static_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sdram_cke && (&sdram_dqm) && (sdram_ba == '0));

    assert_settle_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q < AGE_W'(SETTLE_CYC)) |-> (cmd == 4'b0111));

    assert_pre_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0010) |-> sdram_addr[10]);

    assert_mrs_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000) |-> (sdram_addr[8:7] == 2'b00));

    assert_mrs_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000) |-> (sdram_addr[2:0] != 3'b100 && sdram_addr[2:0] != 3'b101
                              && sdram_addr[2:0] != 3'b110));

    assert_mrs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000) |-> !(sdram_addr[2:0] == 3'b111 && sdram_addr[3]));

    assert_mrs_cas_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000) |-> (sdram_addr[6:4] == 3'b010 || sdram_addr[6:4] == 3'b011));

    assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_err |=> (init_err && !init_done && cmd == 4'b0111));

    assert_ready_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> (init_done && cmd == 4'b0111));

    assert_ready_after_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> ($past(cmd) == 4'b0111 && !init_err));

endmodule

bind sdram_init_seq sdram_init_chk #(
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .DQM_W     (DQM_W),
    .SETTLE_CYC(CLK_FREQ_MHZ * SETTLE_US)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sdram_cke  (sdram_cke),
    .sdram_cs_n (sdram_cs_n),
    .sdram_ras_n(sdram_ras_n),
    .sdram_cas_n(sdram_cas_n),
    .sdram_we_n (sdram_we_n),
    .sdram_dqm  (sdram_dqm),
    .sdram_ba   (sdram_ba),
    .sdram_addr (sdram_addr),
    .init_done  (init_done),
    .init_err   (init_err)
);

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;

    localparam int MHZ  = 50;
    localparam int SUS  = 200;
    localparam int S    = MHZ * SUS;
    localparam int TRP  = 3;
    localparam int TRC  = 7;
    localparam int TMRD = 2;
    localparam int NR0  = 4;
    localparam int NR1  = 1;
    localparam int NR1E = 2;
    localparam int RUN  = S + 100;
    localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

    // {burst_len[2:0], burst_type, cas[2:0], wr_single, legal, req[3:0]}
    localparam int NV = 9;
    localparam logic [12:0] VEC [NV] = '{
        {3'b000, 1'b0, 3'b010, 1'b0, 1'b1, 4'd7},  // R7 len 1
        {3'b001, 1'b1, 3'b011, 1'b1, 1'b1, 4'd7},  // R7 len 2
        {3'b010, 1'b0, 3'b011, 1'b0, 1'b1, 4'd7},  // R7 len 4
        {3'b011, 1'b1, 3'b010, 1'b1, 1'b1, 4'd7},  // R7 len 8
        {3'b111, 1'b0, 3'b011, 1'b0, 1'b1, 4'd8},  // R8 full page sequential
        {3'b111, 1'b1, 3'b011, 1'b0, 1'b0, 4'd8},  // R8 full page interleave
        {3'b101, 1'b0, 3'b010, 1'b0, 1'b0, 4'd7},  // R7 reserved length
        {3'b011, 1'b0, 3'b001, 1'b0, 1'b0, 4'd9},  // R9 cas below
        {3'b011, 1'b0, 3'b100, 1'b1, 1'b0, 4'd9}   // R9 cas above
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] bl = 3'b000;
    logic bt = 1'b0;
    logic [2:0] cl = 3'b010;
    logic ws = 1'b0;

    logic        cke_o [2];
    logic        cs_o  [2];
    logic        ras_o [2];
    logic        cas_o [2];
    logic        we_o  [2];
    logic [1:0]  dqm_o [2];
    logic [1:0]  ba_o  [2];
    logic [12:0] adr_o [2];
    logic        rdy_o [2];
    logic        err_o [2];

    always #10 clk = ~clk;

    sdram_init_seq #(.CLK_FREQ_MHZ(MHZ), .SETTLE_US(SUS), .TRP_CYC(TRP), .TRC_CYC(TRC),
                     .TMRD_CYC(TMRD), .NUM_REF(NR0), .MRS_FIRST(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_burst_len(bl), .cfg_burst_type(bt),
        .cfg_cas_lat(cl), .cfg_wr_single(ws), .sdram_cke(cke_o[0]), .sdram_cs_n(cs_o[0]),
        .sdram_ras_n(ras_o[0]), .sdram_cas_n(cas_o[0]), .sdram_we_n(we_o[0]),
        .sdram_dqm(dqm_o[0]), .sdram_ba(ba_o[0]), .sdram_addr(adr_o[0]),
        .init_done(rdy_o[0]), .init_err(err_o[0]));

    sdram_init_seq #(.CLK_FREQ_MHZ(MHZ), .SETTLE_US(SUS), .TRP_CYC(TRP), .TRC_CYC(TRC),
                     .TMRD_CYC(TMRD), .NUM_REF(NR1), .MRS_FIRST(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_burst_len(bl), .cfg_burst_type(bt),
        .cfg_cas_lat(cl), .cfg_wr_single(ws), .sdram_cke(cke_o[1]), .sdram_cs_n(cs_o[1]),
        .sdram_ras_n(ras_o[1]), .sdram_cas_n(cas_o[1]), .sdram_we_n(we_o[1]),
        .sdram_dqm(dqm_o[1]), .sdram_ba(ba_o[1]), .sdram_addr(adr_o[1]),
        .init_done(rdy_o[1]), .init_err(err_o[1]));

    int n_chk = 0;
    int n_bad = 0;

    int          evk [2][64];
    logic [3:0]  evc [2][64];
    logic [12:0] eva [2][64];
    int          nev [2];
    int          rdy_k [2];
    int          err_k [2];
    int          pin_bad [2];
    int          rdy_drop [2];

    int          xk [64];
    logic [3:0]  xc [64];
    logic [12:0] xa [64];
    int          nx;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string req_name(input logic [3:0] n);
        case (n)
            4'd7:    return "R7";
            4'd8:    return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic string cmd_req(input logic [3:0] c, input int inst);
        if (inst == 1) return "R5";
        case (c)
            PRE:     return "R2";
            REF:     return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [3:0] cmd_of(input int i);
        return {cs_o[i], ras_o[i], cas_o[i], we_o[i]};
    endfunction

    task automatic reset_check(input string req);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk(cmd_of(i) == NOP && cke_o[i] && dqm_o[i] == 2'b11 && adr_o[i] == 13'd0,
                req, "pins during reset", {cmd_of(i), adr_o[i]}, {NOP, 13'd0});
            chk(!rdy_o[i] && !err_o[i], req, "flags during reset",
                {rdy_o[i], err_o[i]}, 0);
        end
    endtask

    task automatic sample(input int k);
        for (int i = 0; i < 2; i++) begin
            if (!cke_o[i] || dqm_o[i] != 2'b11 || ba_o[i] != 2'b00) pin_bad[i]++;
            if (cmd_of(i) != NOP) begin
                if (nev[i] < 64) begin
                    evk[i][nev[i]] = k;
                    evc[i][nev[i]] = cmd_of(i);
                    eva[i][nev[i]] = adr_o[i];
                end
                nev[i]++;
            end else if (adr_o[i] != 13'd0) begin
                pin_bad[i]++;
            end
            if (rdy_o[i] && err_o[i]) pin_bad[i]++;
            if (rdy_o[i] && rdy_k[i] < 0) rdy_k[i] = k;
            if (!rdy_o[i] && rdy_k[i] >= 0) rdy_drop[i]++;
            if (err_o[i] && err_k[i] < 0) err_k[i] = k;
        end
    endtask

    task automatic push(input int k, input logic [3:0] c, input logic [12:0] a);
        xk[nx] = k;
        xc[nx] = c;
        xa[nx] = a;
        nx++;
    endtask

    task automatic run_case(input logic [12:0] v);
        logic [12:0] mw;
        logic        legal;
        string       rq;
        int          k;
        int          exp_rdy;
        int          exp_err;
        {bl, bt, cl, ws} = v[12:5];
        legal = v[4];
        rq = req_name(v[3:0]);
        mw = {3'b000, ws, 2'b00, cl, bt, bl};
        reset_check("R1");
        for (int i = 0; i < 2; i++) begin
            nev[i] = 0; rdy_k[i] = -1; err_k[i] = -1; pin_bad[i] = 0; rdy_drop[i] = 0;
        end
        rst_n = 1'b1;
        for (int c = 1; c <= RUN; c++) begin
            @(negedge clk);
            sample(c);
            if (c == S + 80) begin
                // R11: configuration change after ready must send nothing
                bl = 3'b101;
                cl = 3'b111;
                ws = ~ws;
            end
        end
        for (int i = 0; i < 2; i++) begin
            nx = 0;
            exp_rdy = -1;
            exp_err = -1;
            push(S, PRE, 13'd1 << 10);
            k = S + TRP + 1;
            if (i == 0) begin
                for (int r = 0; r < NR0; r++) begin push(k, REF, 13'd0); k += TRC + 1; end
                if (legal) begin push(k, MRS, mw); exp_rdy = k + TMRD + 1; end
                else exp_err = k;
            end else begin
                if (legal) begin
                    push(k, MRS, mw);
                    k += TMRD + 1;
                    for (int r = 0; r < NR1E; r++) begin push(k, REF, 13'd0); k += TRC + 1; end
                    exp_rdy = k;
                end else exp_err = k;
            end
            chk(nev[i] == nx, legal ? (i == 1 ? "R3" : "R11") : "R10",
                $sformatf("command count inst %0d", i), nev[i], nx);
            for (int e = 0; e < nx && e < nev[i]; e++) begin
                chk(evc[i][e] == xc[e], cmd_req(xc[e], i), $sformatf("cmd %0d inst %0d", e, i),
                    evc[i][e], xc[e]);
                chk(evk[i][e] == xk[e], e == 0 ? "R2" : "R6",
                    $sformatf("cycle of cmd %0d inst %0d", e, i), evk[i][e], xk[e]);
                chk(eva[i][e] == xa[e], xc[e] == MRS ? "R4" : "R2",
                    $sformatf("address of cmd %0d inst %0d", e, i), eva[i][e], xa[e]);
            end
            chk(rdy_k[i] == exp_rdy, "R11", $sformatf("ready cycle inst %0d", i),
                rdy_k[i], exp_rdy);
            chk(err_k[i] == exp_err, rq, $sformatf("error cycle inst %0d", i),
                err_k[i], exp_err);
            chk(pin_bad[i] == 0, "R1", $sformatf("static pins inst %0d", i), pin_bad[i], 0);
            chk(rdy_drop[i] == 0, "R11", $sformatf("ready held inst %0d", i), rdy_drop[i], 0);
        end
    endtask

    initial begin
        #(190000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int v = 0; v < NV; v++) run_case(VEC[v]);

        // R12: reset in the middle of the refresh phase, then full restart
        reset_check("R12");
        rst_n = 1'b1;
        repeat (S + TRP + 10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 2; i++)
            chk(cmd_of(i) == NOP && adr_o[i] == 13'd0, "R12", "pins after mid reset",
                cmd_of(i), NOP);
        run_case({3'b010, 1'b1, 3'b010, 1'b1, 1'b1, 4'd7});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule